// File: doc/BRIEF.md
# Keyed watchdog timer with reset-cause flag

This block is a watchdog timer that runs from the oscillator clock. A fixed divider and a prescaler that software selects feed an 8-bit up-counter. Software must restart the counter on a regular schedule by writing a two-value key sequence. If it fails to do so and the counter overflows, the block does one of two things, chosen by a mode bit. It drives an active-low device reset for a fixed number of oscillator cycles, or it raises an interrupt pulse of the same length.

Two registers hold the configuration: a control register and a status/override register. Writes to either register land only while a protected-access enable input is high. A control write must carry a fixed check code. If the code is wrong, the block resets the device at once. The disable bit can be changed only while a one-shot override bit is still set.

A sticky flag records that a reset came from the watchdog. The watchdog's own reset leaves this flag set, so software can read it after it restarts and learn the cause. Only the power-on reset input clears the flag in hardware.

Top module: `keyed_wdt`

## Requirements
- R1: After power-on reset (rst_ni low), the control register reads 0x0000 and the status register reads 0x0001. wd_rst_no is high and wd_irq_o is low.
- R2: With the watchdog enabled and in reset mode, expiry happens exactly 256·BASE_DIV·P oscillator edges after the edge that completes a service. P is the prescale factor set by control bits 2:0: codes 000 and 001 give 1, and code k≥1 gives 2^(k-1), so 111 gives 64.
- R3: On a reset-mode expiry, wd_rst_no goes low at the expiry edge and stays low for exactly RST_LEN cycles. The reset-cause flag (control bit 7) is set at the same edge.
- R4: Servicing means writing 0x55 and then 0xAA to the key register (address 2, data bits 7:0). Any other value, or 0xAA without a 0x55 written just before it, does not restart the counter.
- R5: A protected control write (address 0) whose bits 5:3 differ from 101 starts the reset pulse at its own write edge and sets the flag. It changes no other control field.
- R6: Control bit 6 disables the watchdog when it is 1. A write changes it only while the override bit is 1. While the watchdog is disabled, no expiry occurs.
- R7: Status bit 0 is the override bit. It is 1 after power-on. Writing 1 to it clears it, and it stays 0 until the next power-on reset.
- R8: The flag is cleared by a valid control write that has bit 7 = 1. Writing 0 to bit 7 leaves it unchanged. The flag survives a watchdog reset, and power-on reset clears it. If a set and a clear fall on the same edge, the set wins.
- R9: When status bit 1 is 1 (interrupt mode), an expiry drives wd_irq_o high for RST_LEN cycles, keeps wd_rst_no high and leaves the flag unchanged. Status bit 2 reads the level of wd_irq_o.
- R10: Control bits 15:8 and 5:3 read as zero. Status bits 15:3 read as zero, and writing those bits has no effect.
- R11: While prot_en_i is low, writes to the control and status registers are ignored, including writes with a bad check code. Key register writes are accepted at any time.
- R12: A service that completes on the same edge as an expiry wins: no expiry occurs, and the next timeout is counted from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| prot_en_i | input | 1 | Protected-access enable for control/status writes |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address: 0 control, 1 status, 2 key |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i (combinational) |
| wd_rst_no | output | 1 | Watchdog device reset, active low |
| wd_irq_o | output | 1 | Watchdog interrupt pulse, active high |

## Verification
Two pairs of events can land on the same clock edge, and the bench places each pair there deliberately by counting edges from a known service point. In the first pair, a control write that clears the flag is timed to hit the exact expiry edge; the flag must read back as set and the reset must still start. In the second pair, the 0xAA half of the key sequence is timed to hit the expiry edge; wd_rst_no must stay high, and the next expiry must come one full period after that edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_KEY  = 2'd2,
    ADDR_NONE = 2'd3
  } wdt_addr_e;

  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;
  localparam logic [2:0] CHK_CODE = 3'b101;

  // control field positions
  localparam int CHK_LO  = 3;
  localparam int CHK_HI  = 5;
  localparam int DIS_BIT = 6;
  localparam int FLG_BIT = 7;
  // status field positions
  localparam int OVR_BIT = 0;
  localparam int MOD_BIT = 1;
endpackage

// File: rtl/wdt_chain.sv
module wdt_chain #(
  parameter int BASE_DIV = 512,
  parameter int CNT_W    = 8,
  parameter int PS_W     = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            en_i,
  input  logic [PS_W-1:0] psel_i,
  output logic            expire_o
);
  localparam int BD_W = (BASE_DIV > 2) ? $clog2(BASE_DIV) : 1;
  localparam int PC_W = (1 << PS_W) - 2;

  logic [BD_W-1:0]  base_q;
  logic [PC_W-1:0]  pre_q, pre_max;
  logic [CNT_W-1:0] cnt_q;
  logic base_tick, pre_tick;

  always_comb begin
    if (psel_i <= PS_W'(1)) pre_max = '0;
    else pre_max = PC_W'((32'd1 << (psel_i - PS_W'(1))) - 32'd1);
  end

  assign base_tick = (base_q == BD_W'(BASE_DIV - 1));
  // >= tolerates a prescale change in mid-count
  assign pre_tick  = base_tick && (pre_q >= pre_max);
  assign expire_o  = en_i && !clr_i && pre_tick && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      pre_q  <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      base_q <= '0;
      pre_q  <= '0;
      cnt_q  <= '0;
    end else if (en_i) begin
      base_q <= base_tick ? '0 : base_q + BD_W'(1);
      if (base_tick) pre_q <= pre_tick ? '0 : pre_q + PC_W'(1);
      if (pre_tick)  cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/wdt_key.sv
module wdt_key (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       wr_i,
  input  logic [7:0] key_i,
  output logic       service_o
);
  import wdt_pkg::*;
  logic armed_q;

  assign service_o = wr_i && armed_q && (key_i == KEY_FIRE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    armed_q <= 1'b0;
    else if (clr_i) armed_q <= 1'b0;
    else if (wr_i)  armed_q <= (key_i == KEY_ARM);
  end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int LEN = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic active_o
);
  localparam int LEN_W = $clog2(LEN + 1);
  logic [LEN_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      left_q   <= '0;
    end else if (fire_i) begin
      active_o <= 1'b1;
      left_q   <= LEN_W'(LEN - 1);
    end else if (active_o) begin
      if (left_q == '0) active_o <= 1'b0;
      else left_q <= left_q - LEN_W'(1);
    end
  end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int BASE_DIV = 512,
  parameter int CNT_W    = 8,
  parameter int PS_W     = 3,
  parameter int RST_LEN  = 512
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        prot_en_i,
  input  logic        bus_we_i,
  input  logic [1:0]  bus_addr_i,
  input  logic [15:0] bus_wdata_i,
  output logic [15:0] bus_rdata_o,
  output logic        wd_rst_no,
  output logic        wd_irq_o
);
  import wdt_pkg::*;
  localparam int N_PULSE = 2; // 0: device reset, 1: interrupt

  logic [PS_W-1:0] psel_q;
  logic dis_q, flag_q, ovr_q, mode_q;
  logic wr_ctrl, wr_stat, wr_key, key_ok, ctrl_ok, ctrl_bad;
  logic service, expire;
  logic [N_PULSE-1:0] fire, active;
  logic [7:0] unused_hi;

  assign unused_hi = bus_wdata_i[15:8];

  assign wr_ctrl  = bus_we_i && prot_en_i && (bus_addr_i == ADDR_CTRL);
  assign wr_stat  = bus_we_i && prot_en_i && (bus_addr_i == ADDR_STAT);
  assign wr_key   = bus_we_i && (bus_addr_i == ADDR_KEY);
  assign key_ok   = (bus_wdata_i[CHK_HI:CHK_LO] == CHK_CODE);
  assign ctrl_ok  = wr_ctrl && key_ok;
  assign ctrl_bad = wr_ctrl && !key_ok;

  wdt_key u_key (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (active[0]),
    .wr_i      (wr_key),
    .key_i     (bus_wdata_i[7:0]),
    .service_o (service)
  );

  wdt_chain #(.BASE_DIV(BASE_DIV), .CNT_W(CNT_W), .PS_W(PS_W)) u_chain (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (service || active[0]),
    .en_i     (!dis_q),
    .psel_i   (psel_q),
    .expire_o (expire)
  );

  assign fire[0] = (expire && !mode_q) || ctrl_bad;
  assign fire[1] = expire && mode_q;

  for (genvar g = 0; g < N_PULSE; g++) begin : g_pulse
    wdt_pulse #(.LEN(RST_LEN)) u_pulse (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .fire_i   (fire[g]),
      .active_o (active[g])
    );
  end

  assign wd_rst_no = !active[0];
  assign wd_irq_o  = active[1];

  // flag and override only see power-on reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psel_q <= '0;
      dis_q  <= 1'b0;
      flag_q <= 1'b0;
      ovr_q  <= 1'b1;
      mode_q <= 1'b0;
    end else begin
      if (fire[0]) flag_q <= 1'b1;
      else if (ctrl_ok && bus_wdata_i[FLG_BIT]) flag_q <= 1'b0;
      if (ctrl_ok) begin
        psel_q <= bus_wdata_i[PS_W-1:0];
        if (ovr_q) dis_q <= bus_wdata_i[DIS_BIT];
      end
      if (wr_stat) begin
        mode_q <= bus_wdata_i[MOD_BIT];
        if (bus_wdata_i[OVR_BIT]) ovr_q <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (wdt_addr_e'(bus_addr_i))
      ADDR_CTRL: begin
        bus_rdata_o[FLG_BIT]    = flag_q;
        bus_rdata_o[DIS_BIT]    = dis_q;
        bus_rdata_o[PS_W-1:0]   = psel_q;
      end
      ADDR_STAT: begin
        bus_rdata_o[OVR_BIT]    = ovr_q;
        bus_rdata_o[MOD_BIT]    = mode_q;
        bus_rdata_o[2]          = wd_irq_o;
      end
      default: bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int RST_LEN = 512
) (
  input logic clk_i,
  input logic rst_ni,
  input logic prot_en_i,
  input logic wd_rst_no,
  input logic wd_irq_o,
  input logic flag_q,
  input logic dis_q,
  input logic ovr_q,
  input logic mode_q
);
  int low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         low_cnt <= 0;
    else if (!wd_rst_no) low_cnt <= low_cnt + 1;
    else                 low_cnt <= 0;
  end

  a_r3_pulse_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wd_rst_no) |-> (low_cnt == RST_LEN));

  a_r8_flag_on_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wd_rst_no) |-> flag_q);

  a_r9_irq_needs_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wd_irq_o) |-> mode_q);

  a_r7_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovr_q |=> !ovr_q);

  a_r6_dis_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovr_q |=> $stable(dis_q));

  a_r11_mode_protected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prot_en_i |=> $stable(mode_q));
endmodule

bind keyed_wdt wdt_checker #(.RST_LEN(RST_LEN)) u_wdt_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .prot_en_i (prot_en_i),
  .wd_rst_no (wd_rst_no),
  .wd_irq_o  (wd_irq_o),
  .flag_q    (flag_q),
  .dis_q     (dis_q),
  .ovr_q     (ovr_q),
  .mode_q    (mode_q)
);

// File: tb/tb_keyed_wdt.sv
`timescale 1ns/1ps
module tb_keyed_wdt;
  localparam int BD  = 4;
  localparam int LEN = 8;
  localparam int N1  = 256 * BD;
  localparam int N2  = 256 * BD * 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic prot_en_i = 1'b0;
  logic bus_we_i = 1'b0;
  logic [1:0] bus_addr_i = 2'd0;
  logic [15:0] bus_wdata_i = '0;
  logic [15:0] bus_rdata_o;
  logic wd_rst_no, wd_irq_o;

  always #10 clk_i = ~clk_i;

  keyed_wdt #(.BASE_DIV(BD), .RST_LEN(LEN)) dut (
    .clk_i, .rst_ni, .prot_en_i, .bus_we_i, .bus_addr_i,
    .bus_wdata_i, .bus_rdata_o, .wd_rst_no, .wd_irq_o
  );

  // scoreboard
  string       tag_q[$];
  int          sel_q[$];
  logic [15:0] exp_q[$];
  event obs_ev;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  initial forever begin
    @(obs_ev);
    while (exp_q.size() > 0) begin
      string t; int s; logic [15:0] e, a;
      t = tag_q.pop_front(); s = sel_q.pop_front(); e = exp_q.pop_front();
      a = (s == 0) ? bus_rdata_o : (s == 1) ? {15'd0, wd_rst_no} : {15'd0, wd_irq_o};
      n_chk++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s actual %h expected %h", t, a, e);
      end
    end
  end

  task automatic expect_val(input string t, input int s, input logic [15:0] e);
    tag_q.push_back(t); sel_q.push_back(s); exp_q.push_back(e);
    -> obs_ev;
    #1;
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] e, input string t);
    bus_addr_i = a;
    #1;
    expect_val(t, 0, e);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1;
    @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic service();
    wr(2'd2, 16'h0055);
    wr(2'd2, 16'h00AA);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    wait_n(3);
    rst_ni = 1'b1;
    // R1 reset state
    rd(2'd0, 16'h0000, "R1 ctrl after por");
    rd(2'd1, 16'h0001, "R1 status after por");
    expect_val("R1 rst_no high", 1, 16'd1);
    expect_val("R1 irq low", 2, 16'd0);
    wait_n(1);

    // R10 reserved bits
    prot_en_i = 1'b1;
    wr(2'd0, 16'hFF2F);
    rd(2'd0, 16'h0007, "R10 ctrl reserved");
    wait_n(1);
    wr(2'd0, 16'h0029);
    wr(2'd1, 16'hFFF8);
    rd(2'd1, 16'h0001, "R10 status reserved");
    rd(2'd0, 16'h0001, "R10 ctrl psel 001");
    wait_n(1);

    // R11 unprotected writes ignored
    prot_en_i = 1'b0;
    wr(2'd0, 16'h0000);
    expect_val("R11 bad check ignored unprotected", 1, 16'd1);
    rd(2'd0, 16'h0001, "R11 ctrl unchanged");
    wait_n(1);
    wr(2'd1, 16'h0003);
    rd(2'd1, 16'h0001, "R11 status unchanged");
    wait_n(1);

    // R2 timeout with key writes while unprotected (R11)
    service();
    wait_n(N1 - 1);
    expect_val("R2 rst high before expiry", 1, 16'd1);
    wait_n(1);
    expect_val("R2 rst low at expiry", 1, 16'd0);
    rd(2'd0, 16'h0081, "R3 flag set by expiry");
    wait_n(LEN - 1);
    expect_val("R3 rst still low at end", 1, 16'd0);
    wait_n(1);
    expect_val("R3 rst released after RST_LEN", 1, 16'd1);
    rd(2'd0, 16'h0081, "R8 flag survives watchdog reset");
    wait_n(1);

    // R8 W1C
    prot_en_i = 1'b1;
    wr(2'd0, 16'h0029);
    rd(2'd0, 16'h0081, "R8 write 0 keeps flag");
    wait_n(1);
    wr(2'd0, 16'h00A9);
    rd(2'd0, 16'h0001, "R8 write 1 clears flag");
    wait_n(1);

    // R4 wrong key orders
    service();
    wr(2'd2, 16'h00AA);
    wr(2'd2, 16'h0055);
    wr(2'd2, 16'h0033);
    wr(2'd2, 16'h00AA);
    wait_n(N1 - 1 - 4);
    expect_val("R4 rst high before expiry", 1, 16'd1);
    wait_n(1);
    expect_val("R4 bad orders did not service", 1, 16'd0);
    wait_n(LEN + 4);

    // R12 service on the expiry edge
    service();
    wait_n(N1 - 2);
    wr(2'd2, 16'h0055);
    wr(2'd2, 16'h00AA);
    expect_val("R12 service beats expiry", 1, 16'd1);
    wait_n(3);
    expect_val("R12 no late reset", 1, 16'd1);
    wait_n(N1 - 4);
    expect_val("R12 rst high before new period", 1, 16'd1);
    wait_n(1);
    expect_val("R12 expiry one period after service", 1, 16'd0);
    wait_n(LEN + 4);

    // R2 prescale code 010
    wr(2'd0, 16'h002A);
    service();
    wait_n(N2 - 1);
    expect_val("R2 prescale 2 rst high", 1, 16'd1);
    wait_n(1);
    expect_val("R2 prescale 2 rst low", 1, 16'd0);
    wait_n(LEN + 4);
    wr(2'd0, 16'h00A9);
    rd(2'd0, 16'h0001, "R8 flag cleared again");
    wait_n(1);

    // R5 bad check code
    wr(2'd0, 16'h00C2);
    expect_val("R5 immediate reset", 1, 16'd0);
    rd(2'd0, 16'h0081, "R5 fields kept, flag set");
    wait_n(LEN + 4);

    // R8 set beats clear on same edge
    wr(2'd0, 16'h00A9);
    rd(2'd0, 16'h0001, "R8 flag clear before collision");
    wait_n(1);
    service();
    wait_n(N1 - 1);
    wr(2'd0, 16'h00A9);
    expect_val("R8 collision reset started", 1, 16'd0);
    rd(2'd0, 16'h0081, "R8 set wins over clear");
    wait_n(LEN + 4);

    // R9 interrupt mode
    wr(2'd0, 16'h00A9);
    wr(2'd1, 16'h0002);
    service();
    wait_n(N1 - 1);
    rd(2'd1, 16'h0003, "R9 status before expiry");
    expect_val("R9 irq low before expiry", 2, 16'd0);
    wait_n(1);
    expect_val("R9 irq high at expiry", 2, 16'd1);
    expect_val("R9 rst stays high", 1, 16'd1);
    rd(2'd1, 16'h0007, "R9 status mirrors irq");
    rd(2'd0, 16'h0001, "R9 flag untouched");
    wait_n(LEN - 1);
    expect_val("R9 irq still high", 2, 16'd1);
    wait_n(1);
    expect_val("R9 irq ends after RST_LEN", 2, 16'd0);
    wr(2'd1, 16'h0000);

    // R6 disable, R7 override
    wr(2'd0, 16'h0069);
    rd(2'd0, 16'h0041, "R6 disable set with override");
    wait_n(1);
    service();
    wait_n(N1 + 20);
    expect_val("R6 no expiry while disabled", 1, 16'd1);
    wr(2'd1, 16'h0001);
    rd(2'd1, 16'h0000, "R7 override cleared");
    wait_n(1);
    wr(2'd1, 16'h0001);
    rd(2'd1, 16'h0000, "R7 override stays 0");
    wait_n(1);
    wr(2'd0, 16'h0029);
    rd(2'd0, 16'h0041, "R6 disable locked");
    wait_n(1);

    // R8 power-on clears flag, R7 override restored
    wr(2'd0, 16'h0000);
    wait_n(LEN + 4);
    rd(2'd0, 16'h00C1, "R8 flag set before por");
    wait_n(1);
    rst_ni = 1'b0;
    wait_n(2);
    rst_ni = 1'b1;
    rd(2'd0, 16'h0000, "R8 por clears flag");
    rd(2'd1, 16'h0001, "R7 por restores override");
    wait_n(2);

    done = 1;
    finish_run();
  end
endmodule